// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

A register-mapped general-purpose I/O block for up to 32 pads, accessed over a simple single-cycle 32-bit read/write bus. Each pad can be driven by software registers (drive value plus output enable, gated by a per-pin direction bit) or handed to an alternate-function path through a per-pin bypass bit. Pad inputs are brought into the clock domain by a two-flop synchronizer before they are read back or watched for interrupts.

Every pin has its own interrupt detector, configured for level or edge sensing with a selectable polarity, or for both edges. Detected events latch into a status register that software clears by reading it, as there is no acknowledge register. Per-pin masking is changed only through a pair of write-one registers, one that unmasks and one that masks, and the resulting mask can be read back. Unmasked status bits are ORed into one interrupt line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers are decoded on bus_addr[5:2] (byte offsets): 0x00 bypass, 0x04 direction, 0x08 output enable, 0x0C drive value, 0x10 synchronized input (read-only), 0x14 mask (read-only), 0x18 unmask (write-only, reads 0), 0x1C mask-set (write-only, reads 0), 0x20 status (read-only, clear on read), 0x24 sense type, 0x28 polarity, 0x2C both-edges. bus_rdata is combinational and is 0 when no read is selected.
- R2: After reset all direction bits are 1 and all mask bits are 1; bypass, output enable, drive value, status, sense type, polarity and both-edges read 0.
- R3: With a bypass bit of 1, pin_out and pin_oe of that pin follow alt_out and alt_oe.
- R4: With a bypass bit of 0, pin_out is the drive value bit and pin_oe is the output-enable bit ANDed with the inverse of the direction bit (direction 1 = input, pad released).
- R5: pin_in passes through two flops: a change sampled at a clock edge appears in the input register after the second following edge.
- R6: Writing 1s to 0x18 clears those mask bits and writing 1s to 0x1C sets them; zero bits leave the mask unchanged.
- R7: irq_out is 1 exactly when some status bit is 1 with its mask bit 0.
- R8: A read of 0x20 returns the status and clears all bits at the same edge; an event detected in that same cycle still sets its bit, so a held level is set again straight away.
- R9: Sense type bit 1 selects level sensing: polarity 1 flags a synchronized high, polarity 0 a synchronized low, in every cycle the level holds.
- R10: Sense type bit 0 selects edge sensing: both-edges bit 1 flags any change; otherwise polarity 1 flags a rising and polarity 0 a falling synchronized edge.
- R11: Writes to read-only registers are ignored, and register bits at or above the pin count read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad drive values |
| pin_oe | output | NPINS | Pad output enables |
| alt_out | input | NPINS | Alternate-function drive values |
| alt_oe | input | NPINS | Alternate-function output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest case is a clearing read landing in the same cycle as a new event, which decides whether a flag survives the read. Held levels make that collision happen on every status read, and the cycle-accurate reference model compares the status contents on each clock, so any read that coincides with a synchronized edge is checked too. Edge tests rely on the three-cycle path from pad to status and space pad changes and reads accordingly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    typedef enum logic [3:0] {
        RG_BYPASS  = 4'd0,
        RG_DIR     = 4'd1,
        RG_OE      = 4'd2,
        RG_DRIVE   = 4'd3,
        RG_INPUT   = 4'd4,
        RG_MASK    = 4'd5,
        RG_UNMASK  = 4'd6,
        RG_SETMASK = 4'd7,
        RG_STATUS  = 4'd8,
        RG_SENSE   = 4'd9,
        RG_POL     = 4'd10,
        RG_BOTH    = 4'd11
    } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (sync_out == $past(async_in, 2))); // R5
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    input  logic [W-1:0] sense_lvl,
    input  logic [W-1:0] pol_hi,
    input  logic [W-1:0] both_edge,
    input  logic         clr_rd,
    output logic [W-1:0] flags
);
    logic [W-1:0] prev_q;
    logic [W-1:0] evt;
    logic [W-1:0] flags_q;

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign evt[i] = sense_lvl[i] ? (pol_hi[i] ? lvl_in[i] : ~lvl_in[i]) :
                        both_edge[i] ? (lvl_in[i] ^ prev_q[i]) :
                        pol_hi[i]    ? (lvl_in[i] & ~prev_q[i]) :
                                       (~lvl_in[i] & prev_q[i]);

        AST_LEVEL_HI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_lvl[i] && pol_hi[i] && lvl_in[i]) |=> flags[i]); // R9
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            flags_q <= '0;
        end else begin
            prev_q  <= lvl_in;
            flags_q <= (clr_rd ? '0 : flags_q) | evt;
        end
    end

    assign flags = flags_q;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rd |=> ((flags & ~$past(evt)) == '0)); // R8
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    output logic              irq_out
);
    initial assert (NPINS >= 1 && NPINS <= DATA_W);

    logic [3:0]       idx;
    logic             wr_hit;
    logic             rd_hit;
    logic             stat_rd;
    logic [NPINS-1:0] wd;

    logic [NPINS-1:0] byp_q, dir_q, oe_q, drv_q, mask_q;
    logic [NPINS-1:0] sense_q, pol_q, both_q;
    logic [NPINS-1:0] in_sync, stat;
    logic [NPINS-1:0] rd_v;

    assign idx     = bus_addr[5:2];
    assign wr_hit  = bus_sel & bus_wr;
    assign rd_hit  = bus_sel & ~bus_wr;
    assign stat_rd = rd_hit & (idx == RG_STATUS);
    assign wd      = bus_wdata[NPINS-1:0];

    gpio_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    gpio_irq_detect #(.W(NPINS)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_in    (in_sync),
        .sense_lvl (sense_q),
        .pol_hi    (pol_q),
        .both_edge (both_q),
        .clr_rd    (stat_rd),
        .flags     (stat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byp_q   <= '0;
            dir_q   <= '1;
            oe_q    <= '0;
            drv_q   <= '0;
            mask_q  <= '1;
            sense_q <= '0;
            pol_q   <= '0;
            both_q  <= '0;
        end else if (wr_hit) begin
            case (idx)
                RG_BYPASS:  byp_q   <= wd;
                RG_DIR:     dir_q   <= wd;
                RG_OE:      oe_q    <= wd;
                RG_DRIVE:   drv_q   <= wd;
                RG_UNMASK:  mask_q  <= mask_q & ~wd;
                RG_SETMASK: mask_q  <= mask_q | wd;
                RG_SENSE:   sense_q <= wd;
                RG_POL:     pol_q   <= wd;
                RG_BOTH:    both_q  <= wd;
                default:    ;
            endcase
        end
    end

    always_comb begin
        rd_v = '0;
        case (idx)
            RG_BYPASS: rd_v = byp_q;
            RG_DIR:    rd_v = dir_q;
            RG_OE:     rd_v = oe_q;
            RG_DRIVE:  rd_v = drv_q;
            RG_INPUT:  rd_v = in_sync;
            RG_MASK:   rd_v = mask_q;
            RG_STATUS: rd_v = stat;
            RG_SENSE:  rd_v = sense_q;
            RG_POL:    rd_v = pol_q;
            RG_BOTH:   rd_v = both_q;
            default:   rd_v = '0;
        endcase
        bus_rdata = rd_hit ? DATA_W'(rd_v) : '0;
    end

    assign pin_out = (byp_q & alt_out) | (~byp_q & drv_q);
    assign pin_oe  = (byp_q & alt_oe)  | (~byp_q & oe_q & ~dir_q);
    assign irq_out = |(stat & ~mask_q);

    AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && idx == RG_UNMASK) |=> ((mask_q & $past(wd)) == '0)); // R6
    AST_SETMASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && idx == RG_SETMASK) |=> ((mask_q & $past(wd)) == $past(wd))); // R6
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq_out); // R7
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    localparam int NP = 12;
    localparam logic [NP-1:0] ALL = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pin_in = '0, alt_out = '0, alt_oe = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic irq_out;

    int n_chk = 0;
    int n_err = 0;
    bit live = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_out(alt_out), .alt_oe(alt_oe), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [NP-1:0] m_byp, m_dir, m_oe, m_drv, m_mask, m_sense, m_pol, m_both, m_stat, m_prev;
    logic [NP-1:0] m_pipe[$];

    function automatic logic [NP-1:0] m_in();
        return m_pipe[0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_byp = '0; m_dir = ALL; m_oe = '0; m_drv = '0; m_mask = ALL;
            m_sense = '0; m_pol = '0; m_both = '0; m_stat = '0; m_prev = '0;
            m_pipe = {'0, '0};
        end else begin
            logic [NP-1:0] s, hit, w;
            s = m_in();
            for (int i = 0; i < NP; i++) begin
                if (m_sense[i])      hit[i] = (s[i] == m_pol[i]);
                else if (m_both[i])  hit[i] = (s[i] != m_prev[i]);
                else                 hit[i] = (s[i] == m_pol[i]) && (m_prev[i] != s[i]);
            end
            if (bus_sel && !bus_wr && bus_addr[5:2] == 4'd8) m_stat = '0;
            m_stat = m_stat | hit;
            w = bus_wdata[NP-1:0];
            if (bus_sel && bus_wr) begin
                case (bus_addr[5:2])
                    4'd0:  m_byp = w;
                    4'd1:  m_dir = w;
                    4'd2:  m_oe = w;
                    4'd3:  m_drv = w;
                    4'd6:  m_mask = m_mask & ~w;
                    4'd7:  m_mask = m_mask | w;
                    4'd9:  m_sense = w;
                    4'd10: m_pol = w;
                    4'd11: m_both = w;
                    default: ;
                endcase
            end
            m_prev = s;
            m_pipe.push_back(pin_in);
            void'(m_pipe.pop_front());
        end
    end

    function automatic logic [31:0] m_rd();
        logic [NP-1:0] v;
        if (!bus_sel || bus_wr) return '0;
        case (bus_addr[5:2])
            4'd0: v = m_byp;   4'd1: v = m_dir;  4'd2: v = m_oe;
            4'd3: v = m_drv;   4'd4: v = m_in(); 4'd5: v = m_mask;
            4'd8: v = m_stat;  4'd9: v = m_sense; 4'd10: v = m_pol;
            4'd11: v = m_both; default: v = '0;
        endcase
        return 32'(v);
    endfunction

    always @(negedge clk) begin
        if (live) begin
            chk("R1 rdata vs model", bus_rdata, m_rd());
            chk("R3 pin_out vs model", 32'(pin_out), 32'((m_byp & alt_out) | (~m_byp & m_drv)));
            chk("R4 pin_oe vs model", 32'(pin_oe), 32'((m_byp & alt_oe) | (~m_byp & m_oe & ~m_dir)));
            chk("R7 irq_out vs model", 32'(irq_out), 32'(|(m_stat & ~m_mask)));
        end
    end

    task automatic wreg(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #3;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #3;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rreg(input logic [5:0] a, output logic [31:0] d);
        @(posedge clk); #3;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk); d = bus_rdata;
        @(posedge clk); #3;
        bus_sel = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        live = 1'b1;

        // R2 reset values
        rreg(6'h00, d); chk("R2 bypass reset", d, 32'h0);
        rreg(6'h04, d); chk("R2 direction reset", d, 32'hFFF);
        rreg(6'h08, d); chk("R2 oe reset", d, 32'h0);
        rreg(6'h14, d); chk("R2 mask reset", d, 32'hFFF);
        rreg(6'h20, d); chk("R2 status reset", d, 32'h0);
        rreg(6'h24, d); chk("R2 sense reset", d, 32'h0);

        // R4 register-driven pads
        wreg(6'h04, 32'h0F0);
        wreg(6'h08, 32'hFFF);
        wreg(6'h0C, 32'hA5A);
        @(negedge clk);
        chk("R4 pin_oe gated by direction", 32'(pin_oe), 32'hF0F);
        chk("R4 pin_out drive value", 32'(pin_out), 32'hA5A);

        // R3 bypass
        alt_out = 12'h001; alt_oe = 12'h001;
        wreg(6'h00, 32'h003);
        @(negedge clk);
        chk("R3 bypass pin_out", 32'(pin_out), 32'hA59);
        chk("R3 bypass pin_oe", 32'(pin_oe), 32'hF0D);
        rreg(6'h00, d); chk("R1 bypass readback", d, 32'h003);

        // R11 upper bits and read-only registers
        wreg(6'h0C, 32'hFFFF_FFFF);
        rreg(6'h0C, d); chk("R11 upper bits read zero", d, 32'hFFF);
        wreg(6'h10, 32'hFFF);
        rreg(6'h10, d); chk("R11 input reg ignores write", d, 32'h0);
        wreg(6'h14, 32'h0);
        rreg(6'h14, d); chk("R11 mask reg ignores write", d, 32'hFFF);

        // R6 unmask / mask-set
        wreg(6'h18, 32'h00F);
        rreg(6'h14, d); chk("R6 unmask", d, 32'hFF0);
        wreg(6'h1C, 32'h001);
        rreg(6'h14, d); chk("R6 mask-set", d, 32'hFF1);
        wreg(6'h18, 32'h000);
        rreg(6'h14, d); chk("R6 zero write no change", d, 32'hFF1);
        rreg(6'h18, d); chk("R1 unmask reads zero", d, 32'h0);

        // R5 two-flop input latency
        @(posedge clk); #3;
        pin_in = 12'h123; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'h10;
        @(negedge clk); chk("R5 input before edge", bus_rdata, 32'h0);
        @(negedge clk); chk("R5 input after one edge", bus_rdata, 32'h0);
        @(negedge clk); chk("R5 input after two edges", bus_rdata, 32'h123);
        @(posedge clk); #3 bus_sel = 1'b0;
        waitc(3);
        rreg(6'h20, d);

        // R9 level sensing, R8 re-set after read
        wreg(6'h1C, 32'hFFF);
        wreg(6'h18, 32'h100);
        wreg(6'h24, 32'h180);
        wreg(6'h28, 32'h100);
        pin_in = 12'h100;
        waitc(4);
        @(negedge clk); chk("R7 irq on unmasked level", 32'(irq_out), 32'h1);
        rreg(6'h20, d); chk("R9 level high and low flagged", d & 32'h180, 32'h180);
        rreg(6'h20, d); chk("R8 held level set again after read", d & 32'h180, 32'h180);
        pin_in = 12'h080;
        waitc(4);
        rreg(6'h20, d);
        rreg(6'h20, d); chk("R9 inactive levels not flagged", d & 32'h180, 32'h0);
        @(negedge clk); chk("R7 irq low with no flags", 32'(irq_out), 32'h0);

        // R10 edge sensing
        wreg(6'h24, 32'h000);
        wreg(6'h28, 32'h200);
        wreg(6'h2C, 32'h400);
        wreg(6'h1C, 32'hFFF);
        wreg(6'h18, 32'h200);
        pin_in = 12'h800;
        waitc(4);
        rreg(6'h20, d);
        pin_in = 12'h600;
        waitc(4);
        @(negedge clk); chk("R7 irq on unmasked rising", 32'(irq_out), 32'h1);
        rreg(6'h20, d); chk("R10 rise/any/fall flags", d, 32'hE00);
        @(negedge clk); chk("R8 read cleared flags", 32'(irq_out), 32'h0);
        pin_in = 12'h000;
        waitc(4);
        rreg(6'h20, d); chk("R10 falling only on any-edge pin", d, 32'h400);

        // R7 masked flag does not raise irq
        pin_in = 12'h400;
        waitc(4);
        @(negedge clk); chk("R7 masked flag keeps irq low", 32'(irq_out), 32'h0);
        rreg(6'h20, d); chk("R10 any-edge rising", d, 32'h400);

        waitc(2);
        live = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule